// File: doc/BRIEF.md
# Double-Buffered DAC Register Bank

This block is the digital front end of a bank of 8-bit converter channels. Each channel keeps its code in two ranks. The first rank is a holding register that a host fills over a shared byte bus. The second rank is the register whose value drives the converter. Each channel has an active-low select. A shared active-high enable qualifies the first write strobe. A shared transfer strobe, combined with a second write strobe, copies every holding register into the output rank in the same clock, so that all channels change together.

All control and data pins are taken as asynchronous. They pass through two flops before any register acts on them. A level that would hold a latch open becomes a load on every clock while it lasts. Because of this, the byte kept after a strobe is released is the last byte present while the strobe was low.

How the pins are tied selects the mode. With every strobe and select held low and the enable held high, the output follows the bus. With the second strobe and the transfer held low, each first-strobe pulse reaches the output directly. With all of them driven separately, the bank is double-buffered. A per-channel pending flag shows which holding registers contain bytes that have not yet been transferred.

Top module: `dbuf_dac_bank`

## Requirements
- R1: A byte written into a channel's holding register does not reach that channel's output while either transfer control is high.
- R2: A channel's holding register loads the bus byte only in a clock where the enable is high, that channel's select is low and the first write strobe is low. In every other clock it keeps its value.
- R3: The output rank loads only in a clock where both the transfer strobe and the second write strobe are low. A high on either one holds every output.
- R4: A change on the pins reaches `dac_out` on the third rising clock edge after it settles: two synchronizer stages plus one register.
- R5: With the enable low, no holding register changes, whatever the selects, the first strobe and the bus do.
- R6: With all selects, both write strobes and the transfer strobe low and the enable high, every output follows the bus byte.
- R7: With the second strobe and the transfer held low, a first-strobe pulse puts the bus byte on the selected output. The byte present while the strobe was low is the one kept after the strobe rises.
- R8: A shared transfer changes only the outputs of channels whose holding register was written since that channel's last transfer.
- R9: A channel's pending flag sets when its holding register loads and clears in any clock in which the output rank loads. If both happen in the same clock, the flag ends clear.
- R10: Reset clears every holding register, every output and every pending flag. Channel c occupies `dac_out[8c+7:8c]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | DW | Byte bus shared by all channels |
| sel_n | input | NCH | Per-channel select, active low |
| load_en | input | 1 | Enable qualifier for the first rank, active high |
| wr1_n | input | 1 | First write strobe, active low |
| wr2_n | input | 1 | Second write strobe, active low |
| xfer_n | input | 1 | Shared transfer strobe, active low |
| dac_out | output | NCH*DW | Output-rank values, channel 0 in the low byte |
| pending | output | NCH | Per-channel flag for a byte not yet transferred |

## Verification
A corrupted holding register is invisible at `dac_out` until the next transfer. After that transfer the wrong byte appears three edges after the transfer pins settle, and it appears only on the channel that was hit. A wrong pending flag shows at once on `pending`. A channel with a clear flag must always show the same byte in both ranks, so a stray load in either rank breaks that pairing in the next clock. A gating fault that lets the enable or a select leak through shows up as an output change that the stimulus did not allow.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  // First rank opens when qualified by enable, select and first strobe.
  function automatic logic rank1_open(input logic le, input logic sel_n, input logic wr1_n);
    return le & ~sel_n & ~wr1_n;
  endfunction

  // Second rank opens only when both transfer controls are low.
  function automatic logic rank2_open(input logic wr2_n, input logic xfer_n);
    return ~wr2_n & ~xfer_n;
  endfunction

  // Pending flag update: a transfer wins over a load in the same clock.
  function automatic logic pend_next(input logic cur, input logic ld_in, input logic ld_dac);
    return ld_dac ? 1'b0 : (ld_in ? 1'b1 : cur);
  endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_bank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_in,
  input  logic          ld_dac,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] dac_q,
  output logic          pend
);
  logic [DW-1:0] in_view;

  // What a transparent first rank would present this clock.
  assign in_view = ld_in ? din : in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      pend  <= 1'b0;
    end else begin
      in_q  <= in_view;
      if (ld_dac) dac_q <= in_view;
      pend  <= pend_next(pend, ld_in, ld_dac);
    end
  end
endmodule

// File: rtl/dbuf_dac_bank.sv
module dbuf_dac_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     bus_data,
  input  logic [NCH-1:0]    sel_n,
  input  logic              load_en,
  input  logic              wr1_n,
  input  logic              wr2_n,
  input  logic              xfer_n,
  output logic [NCH*DW-1:0] dac_out,
  output logic [NCH-1:0]    pending
);
  localparam int CTLW = NCH + 3;

  logic [CTLW-1:0]   ctl_raw, ctl_s;
  logic [NCH-1:0]    s_sel_n;
  logic              s_wr1_n, s_wr2_n, s_xfer_n, s_le;
  logic [DW-1:0]     s_data;
  logic [NCH-1:0]    in_load;
  logic              dac_load;
  logic [NCH*DW-1:0] in_q_all;

  assign ctl_raw = {sel_n, wr1_n, wr2_n, xfer_n};

  // Active-low controls come out of reset idle (high).
  dac_sync #(.W(CTLW), .STAGES(STAGES), .RST_VAL({CTLW{1'b1}})) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );
  dac_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync_le (
    .clk(clk), .rst_n(rst_n), .d(load_en), .q(s_le)
  );
  // Data delayed by the same depth so it stays aligned with its strobes.
  dac_sync #(.W(DW), .STAGES(STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_data), .q(s_data)
  );

  assign {s_sel_n, s_wr1_n, s_wr2_n, s_xfer_n} = ctl_s;
  assign dac_load = rank2_open(s_wr2_n, s_xfer_n);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign in_load[c] = rank1_open(s_le, s_sel_n[c], s_wr1_n);

    dac_channel #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_in  (in_load[c]),
      .ld_dac (dac_load),
      .din    (s_data),
      .in_q   (in_q_all[c*DW +: DW]),
      .dac_q  (dac_out[c*DW +: DW]),
      .pend   (pending[c])
    );
  end
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_le,
  input logic [NCH-1:0]    in_load,
  input logic              dac_load,
  input logic [NCH*DW-1:0] in_q_all,
  input logic [NCH*DW-1:0] dac_out,
  input logic [NCH-1:0]    pending
);
  AST_LE_LOW_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    !s_le |=> $stable(in_q_all)); // R5

  AST_RANK1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load == '0) |=> $stable(in_q_all)); // R2

  AST_RANK2_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load |=> $stable(dac_out)); // R3

  AST_XFER_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> (pending == '0)); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_CLEAN_RANKS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !pending[c] |-> (dac_out[c*DW +: DW] == in_q_all[c*DW +: DW])); // R8

    AST_LOAD_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_load[c] && !dac_load) |=> pending[c]); // R9
  end
endmodule

bind dbuf_dac_bank dac_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_le     (s_le),
  .in_load  (in_load),
  .dac_load (dac_load),
  .in_q_all (in_q_all),
  .dac_out  (dac_out),
  .pending  (pending)
);

// File: tb/dbuf_dac_bank_bench.sv
`timescale 1ns/1ps
module dbuf_dac_bank_bench;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int NV  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DW-1:0]     bus_data = '0;
  logic [NCH-1:0]    sel_n = '1;
  logic              load_en = 1'b0;
  logic              wr1_n = 1'b1;
  logic              wr2_n = 1'b1;
  logic              xfer_n = 1'b1;
  logic [NCH*DW-1:0] dac_out;
  logic [NCH-1:0]    pending;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbuf_dac_bank u_dbuf_dac_bank (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .sel_n(sel_n),
    .load_en(load_en), .wr1_n(wr1_n), .wr2_n(wr2_n), .xfer_n(xfer_n),
    .dac_out(dac_out), .pending(pending)
  );

  // {sel_n, le, wr1_n, wr2_n, xfer_n, data, exp dac_out, exp pending}
  localparam logic [51:0] VEC [NV] = '{
    {4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 32'h00000000, 4'b0000}, // idle
    {4'b1110, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 32'h00000000, 4'b0001}, // R1 write ch0
    {4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 32'h00000000, 4'b0001}, // R2 idle
    {4'b1011, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 32'h00000000, 4'b0101}, // R2 write ch2
    {4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 32'h00000000, 4'b0101}, // idle
    {4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 32'h003C00A5, 4'b0000}, // R8 shared xfer
    {4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 32'h003C00A5, 4'b0000}, // idle
    {4'b1101, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 32'h003C00A5, 4'b0000}, // R5 le low
    {4'b1101, 1'b1, 1'b0, 1'b1, 1'b1, 8'h77, 32'h003C00A5, 4'b0010}, // R9 write ch1
    {4'b1111, 1'b1, 1'b1, 1'b1, 1'b0, 8'h77, 32'h003C00A5, 4'b0010}, // R3 xfer only
    {4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 8'h77, 32'h003C00A5, 4'b0010}, // R3 wr2 only
    {4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 8'h77, 32'h003C77A5, 4'b0000}, // R3 both low
    {4'b0111, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 32'h5A3C77A5, 4'b0000}, // R7 single buf
    {4'b0111, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 32'h5A3C77A5, 4'b0000}, // R7 released
    {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 32'hC3C3C3C3, 4'b0000}, // R6 flow
    {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h18, 32'h18181818, 4'b0000}  // R6 flow
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset out", dac_out, 32'h0);
    check("R10 reset pending", {28'h0, pending}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {sel_n, load_en, wr1_n, wr2_n, xfer_n, bus_data} = VEC[i][51:36];
      repeat (4) @(negedge clk);
      check($sformatf("vec%0d out", i), dac_out, VEC[i][35:4]);
      check($sformatf("vec%0d pending", i), {28'h0, pending}, {28'h0, VEC[i][3:0]});
    end

    // R4: flow-through latency of exactly three edges.
    bus_data = 8'hE7;
    repeat (2) @(negedge clk);
    check("R4 before third edge", dac_out, 32'h18181818);
    @(negedge clk);
    check("R4 at third edge", dac_out, 32'hE7E7E7E7);

    // R5: enable low in flow-through freezes everything.
    load_en = 1'b0;
    repeat (4) @(negedge clk);
    bus_data = 8'h42;
    repeat (4) @(negedge clk);
    check("R5 frozen in flow", dac_out, 32'hE7E7E7E7);
    check("R5 no pending", {28'h0, pending}, 32'h0);

    // R1: double-buffered write to ch3 stays hidden until transfer.
    {wr2_n, xfer_n, wr1_n, sel_n} = {1'b1, 1'b1, 1'b1, 4'b1111};
    load_en = 1'b1;
    repeat (4) @(negedge clk);
    bus_data = 8'h99;
    sel_n = 4'b0111;
    wr1_n = 1'b0;
    repeat (4) @(negedge clk);
    wr1_n = 1'b1;
    sel_n = 4'b1111;
    repeat (4) @(negedge clk);
    check("R1 hidden", dac_out, 32'hE7E7E7E7);
    check("R9 set ch3", {28'h0, pending}, 32'h8);
    {wr2_n, xfer_n} = 2'b00;
    repeat (4) @(negedge clk);
    check("R8 only ch3 moves", dac_out, 32'h99E7E7E7);

    // R10: reset mid-run clears outputs.
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset", dac_out, 32'h0);
    finish_run();
  end
endmodule